// File: doc/BRIEF.md
# Posted-Write Ordering Bridge

This block connects an external bus slave port to an internal master port. Each external request carries an address, an address-space code, a data-size code, a write flag and write data. The request is held until the bridge answers with either an acknowledge pulse or an error pulse. Writes go into a posted-write queue and are acknowledged straight away. The internal side receives them later as commands on a valid/ready channel and reports each completion with a one-cycle done pulse.

A read is an ordering barrier. The bridge first waits until every write it has posted has been issued and completed internally. Only then does it send the read command. It acknowledges the external read when the internal read data arrives, and that data is presented alongside the acknowledge. Only one external transaction is handled at a time. After a response, the master must drop its request before the next one is taken.

Top module: `posted_wr_bridge`

## Requirements
- R1: A write with supported codes, made while fewer than WR_DEPTH writes are outstanding, is acknowledged in the first cycle after the request is sampled, whether or not the internal side is ready.
- R2: A read is acknowledged only in the cycle after the internal read data is valid, and `ext_rdata` then holds that data.
- R3: A read command is not issued internally until every posted write has been signalled complete on `int_wr_done`.
- R4: Internal commands carry the accepted address, codes, write flag and data in the order the external transactions were acknowledged. A command held without ready keeps its valid and fields stable.
- R5: After a response, no further response or internal command is produced for the same request until `ext_req` has been low for a cycle.
- R6: An outstanding write stays counted from its acknowledge until its done pulse. While WR_DEPTH writes are outstanding, a new write's acknowledge is withheld until one completes.
- R7: Address-space codes 0..3 (16, 24, 32 and 64-bit spaces) and size codes 0..3 (8, 16, 32 and 64 bits) are supported. Any code of 4..7 in either field gives a one-cycle `ext_err` instead of an acknowledge, and nothing is issued internally.
- R8: A synchronous active-high reset clears both pulses, drops `int_cmd_valid`, empties the write queue and restores the full write capacity.
- R9: `ext_ack` and `ext_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | input | 1 | External request, held until a response |
| ext_we | input | 1 | 1 = write, 0 = read |
| ext_addr | input | AW | Request address |
| ext_space | input | 3 | Address-space code |
| ext_size | input | 3 | Data-size code |
| ext_wdata | input | DW | Write data |
| ext_ack | output | 1 | Acknowledge pulse |
| ext_err | output | 1 | Unsupported-code error pulse |
| ext_rdata | output | DW | Read data, valid with a read acknowledge |
| int_cmd_valid | output | 1 | Internal command valid |
| int_cmd_ready | input | 1 | Internal command ready |
| int_cmd_we | output | 1 | Internal command is a write |
| int_cmd_addr | output | AW | Internal command address |
| int_cmd_space | output | 3 | Internal command space code |
| int_cmd_size | output | 3 | Internal command size code |
| int_cmd_wdata | output | DW | Internal command write data |
| int_wr_done | input | 1 | One-cycle internal write completion |
| int_rd_valid | input | 1 | Internal read data valid |
| int_rd_data | input | DW | Internal read data |

## Verification
If the outstanding-write count leaks upward, the fault shows in two ways: a later read never gets its acknowledge, or writes stall before the queue is really full. The capacity sweep and the drain test catch this within a few dozen cycles. If the count leaks downward, a read command appears while writes are still incomplete, and this is visible on the command channel in the cycle it is issued. A queue pointer or read-latch fault shows as a wrong address, data or order in the next internal command, or as a wrong read value at the acknowledge. These are checked on every transaction of the full sweep over space code, size code and direction.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SP_16 = 3'd0, SP_24 = 3'd1, SP_32 = 3'd2, SP_64 = 3'd3
  } space_e;

  typedef enum logic [CODE_W-1:0] {
    SZ_8 = 3'd0, SZ_16 = 3'd1, SZ_32 = 3'd2, SZ_64 = 3'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_RDCMD, ST_RDDATA, ST_RESP
  } state_e;
endpackage

// File: rtl/pwb_code_check.sv
module pwb_code_check
  import pwb_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int NUM_SIZES  = 4
) (
  input  logic [CODE_W-1:0] space,
  input  logic [CODE_W-1:0] size,
  output logic              ok
);
  localparam logic [CODE_W-1:0] SP_LIM = CODE_W'(NUM_SPACES);
  localparam logic [CODE_W-1:0] SZ_LIM = CODE_W'(NUM_SIZES);

  // R7: codes at or above the limits are unsupported
  always_comb ok = (space < SP_LIM) && (size < SZ_LIM);
endmodule

// File: rtl/pwb_wr_fifo.sv
module pwb_wr_fifo #(
  parameter int WIDTH = 70,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             load;

  // move the head into the output register when it is free or draining
  always_comb load = (count != '0) && (!out_valid || out_ready);

  // storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (load) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(load);
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/posted_wr_bridge.sv
module posted_wr_bridge
  import pwb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WR_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_req,
  input  logic              ext_we,
  input  logic [AW-1:0]     ext_addr,
  input  logic [CODE_W-1:0] ext_space,
  input  logic [CODE_W-1:0] ext_size,
  input  logic [DW-1:0]     ext_wdata,
  output logic              ext_ack,
  output logic              ext_err,
  output logic [DW-1:0]     ext_rdata,
  output logic              int_cmd_valid,
  input  logic              int_cmd_ready,
  output logic              int_cmd_we,
  output logic [AW-1:0]     int_cmd_addr,
  output logic [CODE_W-1:0] int_cmd_space,
  output logic [CODE_W-1:0] int_cmd_size,
  output logic [DW-1:0]     int_cmd_wdata,
  input  logic              int_wr_done,
  input  logic              int_rd_valid,
  input  logic [DW-1:0]     int_rd_data
);
  localparam int CW   = $clog2(WR_DEPTH + 1);
  localparam int WR_W = AW + 2 * CODE_W + DW;
  localparam logic [CW-1:0] CAP = CW'(WR_DEPTH);

  state_e            state;
  logic [CW-1:0]     posted_cnt;
  logic              code_ok;
  logic              accept_wr;
  logic              wq_valid;
  logic [WR_W-1:0]   wq_data;
  logic [AW-1:0]     wq_addr;
  logic [CODE_W-1:0] wq_space, wq_size;
  logic [DW-1:0]     wq_wdata;
  logic              rd_cmd_v;
  logic [AW-1:0]     rd_addr;
  logic [CODE_W-1:0] rd_space, rd_size;

  pwb_code_check u_code (
    .space (ext_space),
    .size  (ext_size),
    .ok    (code_ok)
  );

  // R1/R6: a write is taken only from idle with room in the posted count
  always_comb accept_wr = (state == ST_IDLE) && ext_req && ext_we &&
                          code_ok && (posted_cnt < CAP);

  pwb_wr_fifo #(.WIDTH(WR_W), .DEPTH(WR_DEPTH)) u_wq (
    .clk       (clk),
    .rst       (rst),
    .push      (accept_wr),
    .push_data ({ext_addr, ext_space, ext_size, ext_wdata}),
    .out_valid (wq_valid),
    .out_data  (wq_data),
    .out_ready (int_cmd_ready)
  );

  always_comb {wq_addr, wq_space, wq_size, wq_wdata} = wq_data;

  // R6: outstanding writes counted from acknowledge until completion pulse
  always_ff @(posedge clk) begin
    if (rst) posted_cnt <= '0;
    else     posted_cnt <= posted_cnt + CW'(accept_wr) - CW'(int_wr_done);
  end

  // control: one external transaction at a time (R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ext_ack  <= 1'b0;
      ext_err  <= 1'b0;
      rd_cmd_v <= 1'b0;
    end else begin
      ext_ack <= 1'b0;
      ext_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ext_req) begin
            if (!code_ok) begin
              ext_err <= 1'b1;          // R7
              state   <= ST_RESP;
            end else if (ext_we) begin
              if (accept_wr) begin
                ext_ack <= 1'b1;        // R1
                state   <= ST_RESP;
              end
            end else begin
              state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (posted_cnt == '0) begin   // R3
            rd_cmd_v <= 1'b1;
            state    <= ST_RDCMD;
          end
        end
        ST_RDCMD: begin
          if (int_cmd_ready) begin
            rd_cmd_v <= 1'b0;
            state    <= ST_RDDATA;
          end
        end
        ST_RDDATA: begin
          if (int_rd_valid) begin
            ext_ack <= 1'b1;            // R2
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (!ext_req) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read command latch and returned data
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr   <= '0;
      rd_space  <= '0;
      rd_size   <= '0;
      ext_rdata <= '0;
    end else begin
      if (state == ST_IDLE && ext_req) begin
        rd_addr  <= ext_addr;
        rd_space <= ext_space;
        rd_size  <= ext_size;
      end
      if (state == ST_RDDATA && int_rd_valid) ext_rdata <= int_rd_data;
    end
  end

  // R4: queued writes and the single read share the command channel
  always_comb begin
    int_cmd_valid = wq_valid | rd_cmd_v;
    int_cmd_we    = wq_valid;
    int_cmd_addr  = wq_valid ? wq_addr  : rd_addr;
    int_cmd_space = wq_valid ? wq_space : rd_space;
    int_cmd_size  = wq_valid ? wq_size  : rd_size;
    int_cmd_wdata = wq_valid ? wq_wdata : '0;
  end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
  import pwb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int WR_DEPTH = 16,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_req,
  input logic          ext_ack,
  input logic          ext_err,
  input logic          int_cmd_valid,
  input logic          int_cmd_ready,
  input logic          int_cmd_we,
  input logic [AW-1:0] int_cmd_addr,
  input logic          int_rd_valid,
  input state_e        state,
  input logic [CW-1:0] posted_cnt
);
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ext_ack |=> !ext_ack);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    ext_err |=> !ext_err);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ext_ack && ext_err));

  a_r6_cap: assert property (@(posedge clk) disable iff (rst)
    posted_cnt <= CW'(WR_DEPTH));

  a_r3_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    (int_cmd_valid && !int_cmd_we) |-> (posted_cnt == '0));

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (int_cmd_valid && !int_cmd_ready) |=>
      (int_cmd_valid && $stable(int_cmd_we) && $stable(int_cmd_addr)));

  a_r2_ack_on_data: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDDATA && int_rd_valid) |=> ext_ack);

  a_r2_no_early_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDDATA && !int_rd_valid) |=> !ext_ack);

  a_r5_one_response: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESP && ext_req) |=> (!ext_ack && !ext_err));
endmodule

bind posted_wr_bridge pwb_checker #(
  .AW(AW), .WR_DEPTH(WR_DEPTH), .CW($clog2(WR_DEPTH + 1))
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ext_req       (ext_req),
  .ext_ack       (ext_ack),
  .ext_err       (ext_err),
  .int_cmd_valid (int_cmd_valid),
  .int_cmd_ready (int_cmd_ready),
  .int_cmd_we    (int_cmd_we),
  .int_cmd_addr  (int_cmd_addr),
  .int_rd_valid  (int_rd_valid),
  .state         (state),
  .posted_cnt    (posted_cnt)
);

// File: tb/posted_wr_bridge_bench.sv
module posted_wr_bridge_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 1'b0, ext_we = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [2:0] ext_space = '0, ext_size = '0;
  logic [DW-1:0] ext_wdata = '0;
  logic ext_ack, ext_err;
  logic [DW-1:0] ext_rdata;
  logic int_cmd_valid, int_cmd_we;
  logic [AW-1:0] int_cmd_addr;
  logic [2:0] int_cmd_space, int_cmd_size;
  logic [DW-1:0] int_cmd_wdata;
  logic int_wr_done = 1'b0, int_rd_valid = 1'b0;
  logic [DW-1:0] int_rd_data = '0;

  bit ready_en = 1'b1, done_en = 1'b1, rd_en = 1'b1;
  logic int_cmd_ready;
  assign int_cmd_ready = ready_en;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // log of commands seen on the internal channel
  logic          log_we   [256];
  logic [AW-1:0] log_addr [256];
  logic [DW-1:0] log_data [256];
  logic [2:0]    log_sp   [256];
  logic [2:0]    log_sz   [256];
  int log_n = 0;
  int done_pend = 0;
  bit rd_hold = 1'b0;
  logic [AW-1:0] rd_addr_h = '0;

  posted_wr_bridge #(.AW(AW), .DW(DW), .WR_DEPTH(DEPTH)) u_posted_wr_bridge (
    .clk(clk), .rst(rst),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_space(ext_space), .ext_size(ext_size), .ext_wdata(ext_wdata),
    .ext_ack(ext_ack), .ext_err(ext_err), .ext_rdata(ext_rdata),
    .int_cmd_valid(int_cmd_valid), .int_cmd_ready(int_cmd_ready),
    .int_cmd_we(int_cmd_we), .int_cmd_addr(int_cmd_addr),
    .int_cmd_space(int_cmd_space), .int_cmd_size(int_cmd_size),
    .int_cmd_wdata(int_cmd_wdata), .int_wr_done(int_wr_done),
    .int_rd_valid(int_rd_valid), .int_rd_data(int_rd_data)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [DW-1:0] rd_value(input logic [AW-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  // internal-side model
  initial forever begin
    @(posedge clk);
    if (rst) begin
      done_pend = 0;
      rd_hold = 1'b0;
      int_wr_done <= 1'b0;
      int_rd_valid <= 1'b0;
    end else begin
      if (int_cmd_valid && int_cmd_ready) begin
        log_we[log_n % 256]   = int_cmd_we;
        log_addr[log_n % 256] = int_cmd_addr;
        log_data[log_n % 256] = int_cmd_wdata;
        log_sp[log_n % 256]   = int_cmd_space;
        log_sz[log_n % 256]   = int_cmd_size;
        log_n++;
        if (int_cmd_we) done_pend++;
        else begin rd_hold = 1'b1; rd_addr_h = int_cmd_addr; end
      end
      if (done_en && done_pend > 0) begin
        int_wr_done <= 1'b1;
        done_pend--;
      end else int_wr_done <= 1'b0;
      if (rd_hold && rd_en) begin
        int_rd_valid <= 1'b1;
        int_rd_data <= rd_value(rd_addr_h);
        rd_hold = 1'b0;
      end else int_rd_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // raise a request and count responses over a number of cycles, keeping it high
  task automatic hold_req(input bit we, input logic [2:0] sp, input logic [2:0] sz,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int cyc, output int n_resp);
    @(negedge clk);
    ext_req = 1'b1; ext_we = we; ext_space = sp; ext_size = sz;
    ext_addr = a; ext_wdata = d;
    n_resp = 0;
    repeat (cyc) begin
      @(negedge clk);
      n_resp += int'(ext_ack | ext_err);
    end
  endtask

  // wait for a response, drop the request, then check the pulse has ended (R9)
  task automatic finish_req(input int limit, output bit got_ack, output bit got_err,
                            output logic [DW-1:0] rd, output int lat);
    lat = 0; got_ack = 1'b0; got_err = 1'b0;
    while (!got_ack && !got_err && lat < limit) begin
      @(negedge clk);
      lat++;
      got_ack = ext_ack; got_err = ext_err;
    end
    rd = ext_rdata;
    ext_req = 1'b0;
    @(negedge clk);
    chk(!ext_ack && !ext_err, "R9 pulse", {ext_ack, ext_err}, 0);
  endtask

  task automatic xfer(input bit we, input logic [2:0] sp, input logic [2:0] sz,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input int limit,
                      output bit got_ack, output bit got_err,
                      output logic [DW-1:0] rd, output int lat);
    int nr;
    hold_req(we, sp, sz, a, d, 0, nr);
    finish_req(limit, got_ack, got_err, rd, lat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ga, ge;
    logic [DW-1:0] rd;
    int lat, nr, n0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(!ext_ack && !ext_err && !int_cmd_valid, "R8 reset",
        {ext_ack, ext_err, int_cmd_valid}, 0);

    // R7/R4/R2: sweep of every space code, size code and direction
    for (int sp = 0; sp < 8; sp++)
      for (int sz = 0; sz < 8; sz++)
        for (int we = 0; we < 2; we++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          bit bad;
          a = 32'h1000_0000 + AW'(sp * 256 + sz * 16 + we * 4);
          d = 32'hC0DE_0000 ^ DW'(sp * 97 + sz * 13 + we);
          bad = (sp > 3) || (sz > 3);
          n0 = log_n;
          xfer(we[0], sp[2:0], sz[2:0], a, d, 60, ga, ge, rd, lat);
          repeat (3) @(negedge clk);
          chk(ge == bad, "R7 error", ge, bad);
          chk(ga == !bad, "R7 ack", ga, !bad);
          if (bad) chk(log_n == n0, "R7 no issue", log_n, n0);
          else begin
            chk(log_n == n0 + 1, "R4 issued once", log_n, n0 + 1);
            chk(log_we[n0] == we[0] && log_addr[n0] == a && log_sp[n0] == sp[2:0] &&
                log_sz[n0] == sz[2:0], "R4 fields", log_addr[n0], a);
            if (we != 0) chk(log_data[n0] == d, "R4 data", log_data[n0], d);
            else chk(rd == rd_value(a), "R2 read data", rd, rd_value(a));
          end
        end

    // R1/R6: fill the posted capacity with the internal side stalled
    ready_en = 1'b0;
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b1, 3'd2, 3'd2, AW'(32'h2000 + i * 4), DW'(32'hAB00 + i), 10, ga, ge, rd, lat);
      chk(ga && lat == 1, "R1 immediate ack", lat, 1);
    end
    hold_req(1'b1, 3'd2, 3'd2, AW'(32'h2000 + DEPTH * 4), DW'(32'hAB00 + DEPTH), 30, nr);
    chk(nr == 0, "R6 ack withheld when full", nr, 0);
    ready_en = 1'b1;
    finish_req(100, ga, ge, rd, lat);
    chk(ga, "R6 ack after completion", ga, 1);
    repeat (40) @(negedge clk);
    chk(log_n == DEPTH + 1, "R4 all issued", log_n, DEPTH + 1);
    for (int i = 0; i <= DEPTH; i++)
      chk(log_addr[i] == AW'(32'h2000 + i * 4) && log_data[i] == DW'(32'hAB00 + i),
          "R4 order", log_addr[i], 32'h2000 + i * 4);

    // R3: read waits for completion, not just issue
    done_en = 1'b0;
    log_n = 0;
    for (int i = 0; i < 3; i++)
      xfer(1'b1, 3'd1, 3'd0, AW'(32'h3000 + i), DW'(i), 10, ga, ge, rd, lat);
    repeat (5) @(negedge clk);
    chk(log_n == 3, "R3 writes issued", log_n, 3);
    hold_req(1'b0, 3'd3, 3'd3, 32'h3100, '0, 20, nr);
    chk(nr == 0 && log_n == 3, "R3 read held back", log_n, 3);
    done_en = 1'b1;
    finish_req(50, ga, ge, rd, lat);
    chk(ga && rd == rd_value(32'h3100), "R3 read after drain", rd, rd_value(32'h3100));
    chk(log_n == 4 && log_we[3] == 1'b0, "R3 read last", log_n, 4);

    // R2: read acknowledge waits for the data
    rd_en = 1'b0;
    n0 = log_n;
    hold_req(1'b0, 3'd0, 3'd1, 32'h4444, '0, 20, nr);
    chk(log_n == n0 + 1, "R2 read issued", log_n, n0 + 1);
    chk(nr == 0, "R2 no ack before data", nr, 0);
    rd_en = 1'b1;
    finish_req(20, ga, ge, rd, lat);
    chk(ga && rd == rd_value(32'h4444), "R2 data with ack", rd, rd_value(32'h4444));

    // R5: a request held high after its response is not served twice
    n0 = log_n;
    hold_req(1'b1, 3'd0, 3'd0, 32'h5000, 32'h55, 8, nr);
    chk(nr == 1, "R5 single response", nr, 1);
    chk(log_n == n0 + 1, "R5 single command", log_n, n0 + 1);
    ext_req = 1'b0;
    @(negedge clk);
    xfer(1'b1, 3'd0, 3'd0, 32'h5004, 32'h56, 10, ga, ge, rd, lat);
    chk(ga && lat == 1, "R5 next request served", lat, 1);
    repeat (5) @(negedge clk);

    // R8: reset in the middle of posted traffic
    ready_en = 1'b0;
    for (int i = 0; i < 5; i++)
      xfer(1'b1, 3'd2, 3'd2, AW'(32'h6000 + i), DW'(i), 10, ga, ge, rd, lat);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    log_n = 0;
    @(negedge clk);
    chk(!int_cmd_valid && !ext_ack && !ext_err, "R8 cleared", int_cmd_valid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b1, 3'd2, 3'd2, AW'(32'h7000 + i), DW'(i), 10, ga, ge, rd, lat);
      chk(ga && lat == 1, "R8 capacity restored", lat, 1);
    end
    hold_req(1'b1, 3'd2, 3'd2, 32'h7100, 32'h1, 10, nr);
    chk(nr == 0, "R8 capacity exact", nr, 0);
    ready_en = 1'b1;
    finish_req(100, ga, ge, rd, lat);
    repeat (40) @(negedge clk);
    chk(log_n == DEPTH + 1 && log_addr[0] == 32'h7000, "R8 no stale writes",
        log_addr[0], 32'h7000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule